// File: doc/BRIEF.md
# Systolic Sliding-History LZ77 Phrase Matcher

The block is the matching core of a streaming LZ77 encoder. It keeps the most recent source symbols in a chain of history cells. The chain advances by one cell for every symbol it accepts, and the newest symbol enters at cell 0. Each cell has its own comparator and its own match-enable flag. A cell's flag stays set only while that cell has matched every symbol of the current phrase. An OR reduction tells whether any match is still alive. A lowest-index priority encoder picks the reported cell, and a counter tracks the phrase length.

One symbol is accepted per cycle under a valid/ready handshake. Each finished phrase leaves the block as a single codeword made of four fields: a history position, a match length, an optional literal symbol, and a flag saying whether the literal is present. Cell index `p` in the position field means the match copies from `p+1` symbols back. A flush input closes an open phrase without supplying a literal. The history is kept across a flush and cleared only by reset.

Top module: `lz77_systolic_matcher`

## Requirements
- R1: After reset `out_valid` is 0 and, with `flush` low, `in_ready` is 1. All history cells are empty.
- R2: If an accepted symbol matches no live cell while the phrase length is 0, the block emits a codeword with `out_pos`=0, `out_len`=0, `out_lit` equal to that symbol and `out_has_lit`=1. It emits it at the clock edge that accepts the symbol.
- R3: A phrase grows by one for every accepted symbol that at least one surviving cell still matches. The first accepted symbol that no surviving cell matches ends the phrase. The codeword then carries `out_len` equal to the number of matched symbols, `out_lit` equal to the breaking symbol and `out_has_lit`=1.
- R4: When several cells survive, the codeword reports the lowest cell index. That index is the most recent of the equally long matches, and index `p` means the match begins `p+1` symbols back.
- R5: A cell that has not been filled since reset never matches, whatever value it holds.
- R6: When a match reaches `MAX_LEN` symbols, a codeword with `out_len`=`MAX_LEN` and `out_has_lit`=0 is emitted on the edge that accepts the symbol that completes it. A new phrase then starts.
- R7: While `flush` is high, `in_ready` is 0. A flush acts on a cycle in which the output slot is free (`out_valid` is 0 or `out_ready` is 1). If a phrase is open, the flush emits its position and length with `out_has_lit`=0. With no open phrase it emits nothing. The history is retained either way.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and all codeword fields hold steady.
- R9: Matches reach back at most `DEPTH` symbols. A symbol seen only further back is treated as unmatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source symbol offered |
| in_ready | output | 1 | Symbol accepted this cycle when high together with in_valid |
| in_sym | input | SYM_W | Source symbol |
| flush | input | 1 | Close the open phrase |
| out_valid | output | 1 | Codeword present |
| out_ready | input | 1 | Consumer takes the codeword |
| out_pos | output | $clog2(DEPTH) | Lowest surviving cell index (distance minus one) |
| out_len | output | $clog2(MAX_LEN+1) | Match length in symbols |
| out_lit | output | SYM_W | Literal symbol ending the phrase |
| out_has_lit | output | 1 | out_lit is meaningful |

## Verification
A corrupted history cell or a wrong match-enable flag changes a codeword's position or length. The error shows on the next codeword, one edge after the phrase ends. A fault in the length counter shows up as a wrong `out_len`, or as a saturation codeword that arrives at the wrong symbol count. A validity chain that lets stale cells match shows within the first few symbols after reset, because zero-valued input would then produce a match instead of a literal.

// File: rtl/lzm_pkg.sv
package lzm_pkg;

    // What the current cycle does to the open phrase
    typedef enum logic [2:0] {
        PH_IDLE,   // nothing accepted, no flush
        PH_GROW,   // symbol matched, phrase continues
        PH_SAT,    // symbol matched and length hit the cap
        PH_BREAK,  // symbol unmatched, phrase ends with literal
        PH_FLUSH   // phrase closed on request
    } ph_evt_e;

    function automatic logic evt_emits(ph_evt_e e, logic open_phrase);
        return (e == PH_SAT) || (e == PH_BREAK) || ((e == PH_FLUSH) && open_phrase);
    endfunction

    function automatic logic evt_restarts(ph_evt_e e);
        return (e == PH_SAT) || (e == PH_BREAK) || (e == PH_FLUSH);
    endfunction

endpackage

// File: rtl/lzm_pe.sv
module lzm_pe #(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             restart,
    input  logic [SYM_W-1:0] prev_sym,
    input  logic             prev_vld,
    input  logic [SYM_W-1:0] cmp_sym,
    output logic [SYM_W-1:0] sym_q,
    output logic             vld_q,
    output logic             hit
);
    logic en_q;

    assign hit = en_q && vld_q && (sym_q == cmp_sym);

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q <= '0;
            vld_q <= 1'b0;
            en_q  <= 1'b1;
        end else begin
            if (shift) begin
                sym_q <= prev_sym;
                vld_q <= prev_vld;
            end
            if (restart)
                en_q <= 1'b1;
            else if (shift)
                en_q <= hit;
        end
    end
endmodule

// File: rtl/lzm_cell_array.sv
module lzm_cell_array #(
    parameter int SYM_W = 8,
    parameter int DEPTH = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             restart,
    input  logic [SYM_W-1:0] new_sym,
    output logic [DEPTH-1:0] hits
);
    logic [SYM_W-1:0] sym_chain [DEPTH];
    logic             vld_chain [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic [SYM_W-1:0] up_sym;
        logic             up_vld;
        if (i == 0) begin : g_head
            assign up_sym = new_sym;
            assign up_vld = 1'b1;
        end else begin : g_body
            assign up_sym = sym_chain[i-1];
            assign up_vld = vld_chain[i-1];
        end
        lzm_pe #(.SYM_W(SYM_W)) u_pe (
            .clk      (clk),
            .rst      (rst),
            .shift    (shift),
            .restart  (restart),
            .prev_sym (up_sym),
            .prev_vld (up_vld),
            .cmp_sym  (new_sym),
            .sym_q    (sym_chain[i]),
            .vld_q    (vld_chain[i]),
            .hit      (hits[i])
        );
    end
endmodule

// File: rtl/lzm_prio.sv
module lzm_prio #(
    parameter int N     = 512,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    assign any = |req;

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/lz77_systolic_matcher.sv
module lz77_systolic_matcher
    import lzm_pkg::*;
#(
    parameter int SYM_W   = 8,
    parameter int DEPTH   = 512,
    parameter int MAX_LEN = 16,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SYM_W-1:0] in_sym,
    input  logic             flush,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [IDX_W-1:0] out_pos,
    output logic [LEN_W-1:0] out_len,
    output logic [SYM_W-1:0] out_lit,
    output logic             out_has_lit
);
    typedef struct packed {
        logic [IDX_W-1:0] pos;
        logic [LEN_W-1:0] len;
        logic [SYM_W-1:0] lit;
        logic             has_lit;
    } cw_t;

    logic             slot_free, accept, flush_act;
    logic             emit, restart;
    logic [DEPTH-1:0] hits;
    logic             any_hit;
    logic [IDX_W-1:0] hit_idx;
    logic [LEN_W-1:0] len_q;
    logic [IDX_W-1:0] pos_q;
    logic             vld_q;
    ph_evt_e          evt;
    cw_t              cw_d, cw_q;

    assign slot_free = !vld_q || out_ready;
    assign in_ready  = slot_free && !flush;
    assign accept    = in_valid && in_ready;
    assign flush_act = flush && slot_free;

    lzm_cell_array #(.SYM_W(SYM_W), .DEPTH(DEPTH)) u_cells (
        .clk     (clk),
        .rst     (rst),
        .shift   (accept),
        .restart (restart),
        .new_sym (in_sym),
        .hits    (hits)
    );

    lzm_prio #(.N(DEPTH), .IDX_W(IDX_W)) u_prio (
        .req (hits),
        .any (any_hit),
        .idx (hit_idx)
    );

    always_comb begin
        evt = PH_IDLE;
        if (accept) begin
            if (!any_hit)
                evt = PH_BREAK;
            else if (len_q == LEN_W'(MAX_LEN - 1))
                evt = PH_SAT;
            else
                evt = PH_GROW;
        end else if (flush_act) begin
            evt = PH_FLUSH;
        end
    end

    assign emit    = evt_emits(evt, len_q != '0);
    assign restart = evt_restarts(evt);

    always_comb begin
        cw_d = '{pos: pos_q, len: len_q, lit: '0, has_lit: 1'b0};
        case (evt)
            PH_SAT:   cw_d = '{pos: hit_idx, len: LEN_W'(MAX_LEN), lit: '0, has_lit: 1'b0};
            PH_BREAK: cw_d = '{pos: pos_q, len: len_q, lit: in_sym, has_lit: 1'b1};
            default:  ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            pos_q <= '0;
            vld_q <= 1'b0;
            cw_q  <= '0;
        end else begin
            if (restart) begin
                len_q <= '0;
                pos_q <= '0;
            end else if (evt == PH_GROW) begin
                len_q <= len_q + 1'b1;
                pos_q <= hit_idx;
            end
            if (emit) begin
                vld_q <= 1'b1;
                cw_q  <= cw_d;
            end else if (out_ready) begin
                vld_q <= 1'b0;
            end
        end
    end

    assign out_valid   = vld_q;
    assign out_pos     = cw_q.pos;
    assign out_len     = cw_q.len;
    assign out_lit     = cw_q.lit;
    assign out_has_lit = cw_q.has_lit;
endmodule

// File: rtl/lzm_checker.sv
module lzm_checker #(
    parameter int SYM_W   = 8,
    parameter int MAX_LEN = 16,
    parameter int IDX_W   = 9,
    parameter int LEN_W   = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             in_ready,
    input logic             flush,
    input logic             out_valid,
    input logic             out_ready,
    input logic [IDX_W-1:0] out_pos,
    input logic [LEN_W-1:0] out_len,
    input logic [SYM_W-1:0] out_lit,
    input logic             out_has_lit,
    input logic [LEN_W-1:0] len_q
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);

    p_literal_pos_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == '0) |-> (out_has_lit && out_pos == '0));

    p_len_cap_r6: assert property (@(posedge clk) disable iff (rst)
        len_q < LEN_W'(MAX_LEN));

    p_sat_nolit_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_len == LEN_W'(MAX_LEN)) |-> !out_has_lit);

    p_flush_block_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> !in_ready);

    p_block_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pos) &&
            $stable(out_len) && $stable(out_lit) && $stable(out_has_lit)));
endmodule

bind lz77_systolic_matcher lzm_checker #(
    .SYM_W   (SYM_W),
    .MAX_LEN (MAX_LEN),
    .IDX_W   (IDX_W),
    .LEN_W   (LEN_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .flush       (flush),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_pos     (out_pos),
    .out_len     (out_len),
    .out_lit     (out_lit),
    .out_has_lit (out_has_lit),
    .len_q       (len_q)
);

// File: tb/lz77_systolic_matcher_tb.sv
module lz77_systolic_matcher_tb;
    localparam int SYM_W = 8;
    localparam int DEPTH = 8;
    localparam int MAXL  = 5;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int LEN_W = $clog2(MAXL + 1);
    localparam int NTAB  = 21;
    // bit 8 set = flush item, else bits 7:0 are a symbol
    localparam logic [8:0] STIM [NTAB] = '{
        9'h041, 9'h042, 9'h041, 9'h042, 9'h041, 9'h042, 9'h043,
        9'h041, 9'h042, 9'h043, 9'h041, 9'h042, 9'h058, 9'h100,
        9'h041, 9'h041, 9'h100, 9'h044, 9'h044, 9'h045, 9'h100
    };

    logic             clk = 1'b0;
    logic             rst, in_valid, in_ready, flush, out_valid, out_ready, out_has_lit;
    logic [SYM_W-1:0] in_sym, out_lit;
    logic [IDX_W-1:0] out_pos;
    logic [LEN_W-1:0] out_len;

    lz77_systolic_matcher #(.SYM_W(SYM_W), .DEPTH(DEPTH), .MAX_LEN(MAXL)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_sym(in_sym),
        .flush(flush), .out_valid(out_valid), .out_ready(out_ready), .out_pos(out_pos),
        .out_len(out_len), .out_lit(out_lit), .out_has_lit(out_has_lit));

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit stall_mode = 0;

    logic [8:0] items [80];
    int         n_items;
    logic [7:0] hs [80];
    bit         fl_after [80];
    int         n_sym;
    int e_pos[80], e_len[80], e_lit[80], e_hl[80], n_exp;
    int g_pos[80], g_len[80], g_lit[80], g_hl[80], n_got;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0; flush = 1'b0; out_ready = 1'b1; in_sym = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic push(input logic [8:0] it);
        items[n_items] = it;
        n_items++;
    endtask

    // Reference encoder: greedy longest match, lowest distance on ties
    task automatic build_ref();
        int p, se, best, bd, len;
        n_sym = 0;
        for (int i = 0; i < 80; i++) fl_after[i] = 0;
        for (int i = 0; i < n_items; i++) begin
            if (items[i][8]) begin
                if (n_sym > 0) fl_after[n_sym-1] = 1;
            end else begin
                hs[n_sym] = items[i][7:0];
                n_sym++;
            end
        end
        n_exp = 0;
        p = 0;
        while (p < n_sym) begin
            se = n_sym;
            for (int j = n_sym - 1; j >= p; j--) if (fl_after[j]) se = j + 1;
            best = 0; bd = 0;
            for (int d = 1; d <= DEPTH; d++) begin
                if (p - d >= 0) begin
                    len = 0;
                    while (len < MAXL && p + len < se && hs[p+len] == hs[p+len-d]) len++;
                    if (len > best) begin best = len; bd = d; end
                end
            end
            if (best == MAXL) begin
                e_pos[n_exp] = bd - 1; e_len[n_exp] = MAXL; e_lit[n_exp] = 0; e_hl[n_exp] = 0;
                n_exp++; p += MAXL;
            end else if (p + best < se) begin
                e_pos[n_exp] = (best > 0) ? bd - 1 : 0; e_len[n_exp] = best;
                e_lit[n_exp] = hs[p+best]; e_hl[n_exp] = 1;
                n_exp++; p += best + 1;
            end else begin
                if (best > 0) begin
                    e_pos[n_exp] = bd - 1; e_len[n_exp] = best; e_lit[n_exp] = 0; e_hl[n_exp] = 0;
                    n_exp++;
                end
                p = se;
            end
        end
    endtask

    task automatic sample_out();
        if (out_valid && out_ready && n_got < 80) begin
            g_pos[n_got] = out_pos; g_len[n_got] = out_len;
            g_lit[n_got] = out_lit; g_hl[n_got] = out_has_lit;
            n_got++;
        end
    endtask

    task automatic drive_items();
        bit taken;
        n_got = 0;
        for (int i = 0; i < n_items; i++) begin
            taken = 0;
            while (!taken) begin
                @(negedge clk);
                cyc++;
                out_ready = stall_mode ? ((cyc % 3) != 0) : 1'b1;
                flush     = items[i][8];
                in_valid  = !items[i][8];
                in_sym    = items[i][7:0];
                #2;
                sample_out();
                taken = items[i][8] ? (!out_valid || out_ready) : in_ready;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; flush = 1'b0; out_ready = 1'b1;
        for (int k = 0; k < 6; k++) begin
            #2; sample_out();
            @(negedge clk);
        end
    endtask

    task automatic run_case(input string req);
        build_ref();
        drive_items();
        check(n_got == n_exp, req, "codeword count", n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            check(g_pos[i] == e_pos[i], req, $sformatf("cw%0d pos", i), g_pos[i], e_pos[i]);
            check(g_len[i] == e_len[i], req, $sformatf("cw%0d len", i), g_len[i], e_len[i]);
            check(g_hl[i] == e_hl[i], req, $sformatf("cw%0d has_lit", i), g_hl[i], e_hl[i]);
            check(g_lit[i] == e_lit[i], req, $sformatf("cw%0d lit", i), g_lit[i], e_lit[i]);
        end
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [SYM_W-1:0] held;
        do_reset();
        #2;
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

        // Table walk, free-flowing output then throttled output
        for (int pass = 0; pass < 2; pass++) begin
            do_reset();
            stall_mode = (pass == 1);
            n_items = 0;
            for (int i = 0; i < NTAB; i++) push(STIM[i]);
            run_case(pass == 0 ? "R3" : "R8");
        end
        stall_mode = 0;

        // R2: distinct symbols give literal codewords
        do_reset(); n_items = 0;
        push(9'h011); push(9'h022); push(9'h033); push(9'h100);
        run_case("R2");
        check(g_len[0] == 0 && g_hl[0] == 1, "R2", "first literal len", g_len[0], 0);

        // R5: zero symbols after reset must not hit empty cells
        do_reset(); n_items = 0;
        push(9'h000); push(9'h000); push(9'h000); push(9'h100);
        run_case("R5");
        check(g_len[0] == 0 && g_lit[0] == 0, "R5", "first zero is literal", g_len[0], 0);

        // R4: two equal-length candidates, lower index wins
        do_reset(); n_items = 0;
        push(9'h005); push(9'h006); push(9'h005); push(9'h006); push(9'h007);
        push(9'h005); push(9'h006); push(9'h008); push(9'h100);
        run_case("R4");
        check(g_pos[n_got-1] == 2 && g_len[n_got-1] == 2, "R4", "tie position", g_pos[n_got-1], 2);

        // R6: long run saturates at MAXL
        do_reset(); n_items = 0;
        for (int i = 0; i < 8; i++) push(9'h077);
        push(9'h100);
        run_case("R6");
        check(g_len[1] == MAXL && g_hl[1] == 0, "R6", "saturated length", g_len[1], MAXL);

        // R9: repeat beyond window reach
        do_reset(); n_items = 0;
        for (int i = 1; i <= 10; i++) push(9'(i));
        push(9'h001); push(9'h002); push(9'h009); push(9'h00A); push(9'h100);
        run_case("R9");
        check(g_len[10] == 0, "R9", "distance 10 unmatched", g_len[10], 0);

        // R7: flush with and without an open phrase, history kept
        do_reset(); n_items = 0;
        push(9'h004); push(9'h100); push(9'h100); push(9'h004); push(9'h004);
        push(9'h100); push(9'h004); push(9'h100);
        run_case("R7");
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_sym = 8'h04;
        #2;
        check(in_ready == 1'b0, "R7", "in_ready during flush", in_ready, 0);
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;

        // R8: held codeword under backpressure
        do_reset();
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_sym = 8'h3C;
        @(negedge clk);
        in_sym = 8'h3D;
        #2;
        check(out_valid == 1'b1, "R8", "codeword present", out_valid, 1);
        check(in_ready == 1'b0, "R8", "in_ready blocked", in_ready, 0);
        held = out_lit;
        @(negedge clk);
        #2;
        check(out_lit == held && out_lit == 8'h3C, "R8", "literal held", out_lit, 8'h3C);
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b0;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule